// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset requests into one on-chip system reset. The requests are power-on, brown-out, an active-low external reset pin and a watchdog time-out. When any request appears, the block sets a reset latch and clears its two timers. Once every request has gone away, a power-up delay timer counts a selectable number of ticks of a slow timer clock. When that delay expires, an oscillator start-up counter counts 16 rising edges of the oscillator clock. It counts only while the oscillator is flagged as valid. The system reset is released only when the start-up count completes. A new request at any point restarts the whole sequence.

All request, sleep and oscillator-valid inputs are synchronized into the block clock. The slow tick and the oscillator clock are also synchronized, and their rising edges are detected in the block clock domain. Two status flags record the kind of reset that occurred: a time-out flag and a power-down flag. A wake-up from sleep caused by the pin or the watchdog goes through the full delay sequence, just like any other reset.

Top module: `reset_sequencer`

## Requirements
- R1: Each source forces `sys_rst` to 1 on the third rising clock edge after the request is applied. The sources are `por_req`=1, `bor_req`=1, `ext_rst_n`=0 and `wdt_expire`=1.
- R2: A request during the delay stage or the start-up stage clears both timers. After the request ends, the full delay plus start-up sequence runs again.
- R3: While any synchronized request is active, `sys_rst` stays 1 and the delay timer does not advance.
- R4: The delay stage lasts a number of `tick_slow` rising edges chosen by `dly_sel`. The select is sampled when the last request ends. The encoding is 00 = SEL0 (nominal 18 ms), 01 = SEL1 (4.5 ms), 10 = SEL2 (288 ms) and 11 = SEL3 (72 ms).
- R5: The start-up stage begins only after the delay stage has ended. It counts 16 `osc_clk` rising edges, and only edges seen while `osc_ok` is 1 are counted.
- R6: `sys_rst` falls only on the edge where the start-up count completes.
- R7: A power-on or brown-out request sets `stat_to`=1 and `stat_pd`=1.
- R8: A watchdog request while running clears `stat_to` and leaves `stat_pd` unchanged. A watchdog request while `sleep_mode`=1 clears both flags.
- R9: A pin request while `sleep_mode`=1 clears `stat_pd` and leaves `stat_to` unchanged. A pin request while running leaves both flags unchanged.
- R10: When requests begin on the same cycle, the flags follow one priority order. Power-on and brown-out come first, then the watchdog, then the pin.
- R11: A pin or watchdog wake-up from sleep runs the full reset sequence and does not release reset early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_req | input | 1 | Power-on reset request, active high |
| bor_req | input | 1 | Brown-out reset request, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_expire | input | 1 | Watchdog time-out request, active high |
| tick_slow | input | 1 | Slow timer clock; its rising edges pace the delay stage |
| osc_clk | input | 1 | Oscillator clock; its rising edges pace the start-up stage |
| osc_ok | input | 1 | Oscillator amplitude valid |
| sleep_mode | input | 1 | Core is in sleep |
| dly_sel | input | 2 | Delay stage length select |
| sys_rst | output | 1 | System reset, active high, registered |
| stat_to | output | 1 | Time-out status flag, registered |
| stat_pd | output | 1 | Power-down status flag, registered |

## Verification
If the delay counter or the select latch holds a wrong value, reset is released too early or too late. The error therefore appears only at the moment `sys_rst` falls, which can be many tick periods after the fault. If the start-up counter is corrupted or ignores `osc_ok`, the release edge also moves, by whole oscillator periods. A fault in the flag logic shows on `stat_to` and `stat_pd` one cycle after a request is synchronized. A reference model compared on every clock therefore catches a flag fault immediately and a timer fault at the release cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    SQ_HOLD  = 2'd0,
    SQ_DELAY = 2'd1,
    SQ_START = 2'd2,
    SQ_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[CHAIN_W-WIDTH-1:0], d};
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/rsq_edge.sv
module rsq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic rise
);
  logic lvl;
  logic lvl_q;

  rsq_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .d   (d),
    .q   (lvl)
  );

  always_ff @(posedge clk) lvl_q <= lvl;

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/rsq_pwrt.sv
module rsq_pwrt #(
  parameter int SEL0_TICKS = 72,
  parameter int SEL1_TICKS = 18,
  parameter int SEL2_TICKS = 1152,
  parameter int SEL3_TICKS = 288
) (
  input  logic       clk,
  input  logic       clear,
  input  logic       load,
  input  logic [1:0] sel,
  input  logic       run,
  input  logic       tick,
  output logic       done
);
  localparam int MAX01 = (SEL0_TICKS > SEL1_TICKS) ? SEL0_TICKS : SEL1_TICKS;
  localparam int MAX23 = (SEL2_TICKS > SEL3_TICKS) ? SEL2_TICKS : SEL3_TICKS;
  localparam int MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CW    = (MAXT < 2) ? 1 : $clog2(MAXT);

  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (sel_q)
      2'd0:    last = CW'(SEL0_TICKS - 1);
      2'd1:    last = CW'(SEL1_TICKS - 1);
      2'd2:    last = CW'(SEL2_TICKS - 1);
      default: last = CW'(SEL3_TICKS - 1);
    endcase
  end

  assign done = run & tick & (cnt == last);

  always_ff @(posedge clk) begin
    if (load) sel_q <= sel;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= done ? '0 : cnt + CW'(1);
    end
  end

  // R4
  pwrt_range_chk: assert property (@(posedge clk) disable iff (clear)
    run |-> (cnt <= last));

  // R4
  pwrt_wrap_chk: assert property (@(posedge clk) disable iff (clear)
    done |=> (cnt == '0));

  // R3
  pwrt_frozen_chk: assert property (@(posedge clk) disable iff (clear)
    !run |=> $stable(cnt));
endmodule

// File: rtl/rsq_ost.sv
module rsq_ost #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic clear,
  input  logic run,
  input  logic edge_i,
  input  logic ok,
  output logic done
);
  localparam int CW = (CYCLES < 3) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step = run & edge_i & ok;
  assign done = step & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= done ? '0 : cnt + CW'(1);
    end
  end

  // R5
  ost_idle_chk: assert property (@(posedge clk) disable iff (clear)
    (run && !ok) |=> $stable(cnt));

  // R5
  ost_range_chk: assert property (@(posedge clk) disable iff (clear)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/rsq_flags.sv
module rsq_flags (
  input  logic clk,
  input  logic pwr_lvl,
  input  logic wdt_lvl,
  input  logic pin_lvl,
  input  logic sleep,
  output logic to_q,
  output logic pd_q
);
  logic pwr_prev;
  logic wdt_prev;
  logic pin_prev;
  logic pwr_rise;
  logic wdt_rise;
  logic pin_rise;

  assign pwr_rise = pwr_lvl & ~pwr_prev;
  assign wdt_rise = wdt_lvl & ~wdt_prev;
  assign pin_rise = pin_lvl & ~pin_prev;

  always_ff @(posedge clk) begin
    pwr_prev <= pwr_lvl;
    wdt_prev <= wdt_lvl;
    pin_prev <= pin_lvl;
  end

  always_ff @(posedge clk) begin
    if (pwr_rise) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (wdt_rise) begin
      to_q <= 1'b0;
      if (sleep) pd_q <= 1'b0;
    end else if (pin_rise) begin
      if (sleep) pd_q <= 1'b0;
    end
  end

  // R7
  pwr_flags_chk: assert property (@(posedge clk)
    pwr_rise |=> (to_q && pd_q));

  // R8
  wdt_to_chk: assert property (@(posedge clk)
    (wdt_rise && !pwr_rise) |=> !to_q);

  // R9
  pin_run_chk: assert property (@(posedge clk)
    (pin_rise && !pwr_rise && !wdt_rise && !sleep) |=> ($stable(to_q) && $stable(pd_q)));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int SEL0_TICKS  = 72,
  parameter int SEL1_TICKS  = 18,
  parameter int SEL2_TICKS  = 1152,
  parameter int SEL3_TICKS  = 288,
  parameter int OST_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       bor_req,
  input  logic       ext_rst_n,
  input  logic       wdt_expire,
  input  logic       tick_slow,
  input  logic       osc_clk,
  input  logic       osc_ok,
  input  logic       sleep_mode,
  input  logic [1:0] dly_sel,
  output logic       sys_rst,
  output logic       stat_to,
  output logic       stat_pd
);
  import rsq_pkg::*;

  localparam int NLVL = 6;

  logic [NLVL-1:0] lvl_raw;
  logic [NLVL-1:0] lvl_s;
  logic            por_s;
  logic            bor_s;
  logic            pin_s;
  logic            wdt_s;
  logic            ok_s;
  logic            sleep_s;
  logic            tick_rise;
  logic            osc_rise;
  logic            any_req;
  logic            pwrt_done;
  logic            ost_done;
  seq_state_t      state;
  seq_state_t      state_nxt;

  assign lvl_raw = {por_req, bor_req, ~ext_rst_n, wdt_expire, osc_ok, sleep_mode};

  rsq_sync #(.WIDTH(NLVL), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk (clk),
    .d   (lvl_raw),
    .q   (lvl_s)
  );

  assign {por_s, bor_s, pin_s, wdt_s, ok_s, sleep_s} = lvl_s;
  assign any_req = por_s | bor_s | pin_s | wdt_s;

  rsq_edge #(.STAGES(SYNC_STAGES)) u_tick_edge (
    .clk  (clk),
    .d    (tick_slow),
    .rise (tick_rise)
  );

  rsq_edge #(.STAGES(SYNC_STAGES)) u_osc_edge (
    .clk  (clk),
    .d    (osc_clk),
    .rise (osc_rise)
  );

  rsq_pwrt #(
    .SEL0_TICKS (SEL0_TICKS),
    .SEL1_TICKS (SEL1_TICKS),
    .SEL2_TICKS (SEL2_TICKS),
    .SEL3_TICKS (SEL3_TICKS)
  ) u_pwrt (
    .clk   (clk),
    .clear (any_req),
    .load  ((state == SQ_HOLD) && !any_req),
    .sel   (dly_sel),
    .run   (state == SQ_DELAY),
    .tick  (tick_rise),
    .done  (pwrt_done)
  );

  rsq_ost #(.CYCLES(OST_CYCLES)) u_ost (
    .clk    (clk),
    .clear  (any_req),
    .run    (state == SQ_START),
    .edge_i (osc_rise),
    .ok     (ok_s),
    .done   (ost_done)
  );

  rsq_flags u_flags (
    .clk     (clk),
    .pwr_lvl (por_s | bor_s),
    .wdt_lvl (wdt_s),
    .pin_lvl (pin_s),
    .sleep   (sleep_s),
    .to_q    (stat_to),
    .pd_q    (stat_pd)
  );

  always_comb begin
    state_nxt = state;
    if (any_req) begin
      state_nxt = SQ_HOLD;
    end else begin
      case (state)
        SQ_HOLD:  state_nxt = SQ_DELAY;
        SQ_DELAY: if (pwrt_done) state_nxt = SQ_START;
        SQ_START: if (ost_done) state_nxt = SQ_RUN;
        default:  state_nxt = SQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state   <= state_nxt;
    sys_rst <= (state_nxt != SQ_RUN);
  end

  // R1
  req_rst_chk: assert property (@(posedge clk)
    any_req |=> sys_rst);

  // R3
  hold_req_chk: assert property (@(posedge clk)
    any_req |=> (state == SQ_HOLD));

  // R6
  release_order_chk: assert property (@(posedge clk) disable iff (any_req)
    $fell(sys_rst) |-> ($past(state) == SQ_START));

  // R5
  start_after_delay_chk: assert property (@(posedge clk) disable iff (any_req)
    (state == SQ_START) |-> ($past(state) == SQ_DELAY || $past(state) == SQ_START));
endmodule

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
  localparam int T0 = 4;
  localparam int T1 = 2;
  localparam int T2 = 7;
  localparam int T3 = 5;
  localparam int TP = 10;
  localparam int OP = 6;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       bor = 1'b0;
  logic       pin_n = 1'b1;
  logic       wdt = 1'b0;
  logic       tick = 1'b0;
  logic       osc = 1'b0;
  logic       ok = 1'b1;
  logic       slp = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       sys_rst;
  logic       stat_to;
  logic       stat_pd;

  int  checks = 0;
  int  fails = 0;
  bit  armed = 1'b0;
  bit  done_f = 1'b0;

  reset_sequencer #(
    .SEL0_TICKS (T0),
    .SEL1_TICKS (T1),
    .SEL2_TICKS (T2),
    .SEL3_TICKS (T3)
  ) dut (
    .clk        (clk),
    .por_req    (por),
    .bor_req    (bor),
    .ext_rst_n  (pin_n),
    .wdt_expire (wdt),
    .tick_slow  (tick),
    .osc_clk    (osc),
    .osc_ok     (ok),
    .sleep_mode (slp),
    .dly_sel    (sel),
    .sys_rst    (sys_rst),
    .stat_to    (stat_to),
    .stat_pd    (stat_pd)
  );

  always #2.5 clk = ~clk;

  int tc = 0;
  int oc = 0;
  always @(negedge clk) begin
    tc++;
    if (tc == TP / 2) begin tc = 0; tick = ~tick; end
    oc++;
    if (oc == OP / 2) begin oc = 0; osc = ~osc; end
  end

  // Behavioural reference: two synchronizer stages, previous-value history for edges.
  logic [7:0] h1 = '0, h2 = '0, h3 = '0;
  int mst = 0, mp = 0, mo = 0, msel = 0;
  bit mrst = 1'b0, mto = 1'b0, mpd = 1'b0;

  function automatic int lim_of(int s);
    case (s)
      0: return T0;
      1: return T1;
      2: return T2;
      default: return T3;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] cur, pv;
    cur = h2;
    pv  = h3;
    if (|cur[7:4]) begin
      mst = 0; mp = 0; mo = 0;
    end else begin
      case (mst)
        0: begin mst = 1; msel = int'(sel); end
        1: if (cur[3] && !pv[3]) begin
             mp++;
             if (mp == lim_of(msel)) begin mst = 2; mp = 0; end
           end
        2: if (cur[2] && !pv[2] && cur[1]) begin
             mo++;
             if (mo == 16) mst = 3;
           end
        default: mst = 3;
      endcase
    end
    mrst = (mst != 3);
    if ((cur[7] && !pv[7]) || (cur[6] && !pv[6])) begin
      mto = 1'b1; mpd = 1'b1;
    end else if (cur[4] && !pv[4]) begin
      mto = 1'b0;
      if (cur[0]) mpd = 1'b0;
    end else if (cur[5] && !pv[5]) begin
      if (cur[0]) mpd = 1'b0;
    end
    h3 = h2;
    h2 = h1;
    h1 = {por, bor, ~pin_n, wdt, tick, osc, ok, slp};
  end

  task automatic check(bit good, string tag, int act, int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done_f) begin
      check(sys_rst == mrst, "R2/R4/R5/R6 sys_rst vs model", int'(sys_rst), int'(mrst));
      check(stat_to == mto, "R7/R8/R10 stat_to vs model", int'(stat_to), int'(mto));
      check(stat_pd == mpd, "R7/R8/R9 stat_pd vs model", int'(stat_pd), int'(mpd));
    end
  end

  // mask bits: 0 power-on, 1 brown-out, 2 pin, 3 watchdog
  task automatic apply(logic [3:0] m, int hold);
    @(negedge clk);
    if (m[0]) por = 1'b1;
    if (m[1]) bor = 1'b1;
    if (m[2]) pin_n = 1'b0;
    if (m[3]) wdt = 1'b1;
    repeat (3) @(negedge clk);
    check(sys_rst == 1'b1, "R1 request drives reset", int'(sys_rst), 1);
    if (hold > 3) repeat (hold - 3) @(negedge clk);
    check(sys_rst == 1'b1, "R3 reset held while request active", int'(sys_rst), 1);
    por = 1'b0; bor = 1'b0; pin_n = 1'b1; wdt = 1'b0;
  endtask

  task automatic wait_rel(output int n);
    n = 0;
    while (sys_rst !== 1'b0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic chk_flags(int eto, int epd, string tag);
    check(stat_to == eto[0], {tag, " to"}, int'(stat_to), eto);
    check(stat_pd == epd[0], {tag, " pd"}, int'(stat_pd), epd);
  endtask

  task automatic chk_span(int n, int lim, string tag);
    int lo, hi;
    lo = (lim - 1) * TP + 15 * OP;
    hi = (lim + 1) * TP + 17 * OP + 10;
    check(n >= lo && n <= hi, tag, n, lim * TP + 16 * OP);
  endtask

  initial begin
    int n, d1, d2, d3;
    repeat (6) @(negedge clk);
    armed = 1'b1;
    check(sys_rst == 1'b1, "R1 power-on holds reset", int'(sys_rst), 1);
    por = 1'b0;
    wait_rel(n);
    check(sys_rst == 1'b0, "R6 release after power-up", int'(sys_rst), 0);
    chk_span(n, T0, "R4 select 00 span");
    chk_flags(1, 1, "R7 power-on flags");

    sel = 2'd1; apply(4'b0100, 4); wait_rel(d1);
    chk_span(d1, T1, "R4 select 01 span");
    chk_flags(1, 1, "R9 pin while running keeps flags");
    sel = 2'd2; apply(4'b0100, 4); wait_rel(d2);
    chk_span(d2, T2, "R4 select 10 span");
    check(d2 > d1, "R4 longer select gives longer hold", d2, d1);
    sel = 2'd3; apply(4'b0100, 4); wait_rel(d3);
    chk_span(d3, T3, "R4 select 11 span");

    sel = 2'd0; apply(4'b1000, 3); wait_rel(n);
    chk_flags(0, 1, "R8 watchdog while running");
    apply(4'b0010, 5); wait_rel(n);
    chk_flags(1, 1, "R7 brown-out flags");

    slp = 1'b1; apply(4'b0100, 3); wait_rel(n);
    chk_span(n, T0, "R11 pin wake runs full sequence");
    chk_flags(1, 0, "R9 pin in sleep");
    slp = 1'b0;

    apply(4'b0001, 4); wait_rel(n);
    slp = 1'b1; apply(4'b1000, 3); wait_rel(n);
    chk_span(n, T0, "R11 watchdog wake runs full sequence");
    chk_flags(0, 0, "R8 watchdog wake from sleep");
    slp = 1'b0;

    apply(4'b0001, 4); wait_rel(n);
    slp = 1'b1; apply(4'b1100, 3); wait_rel(n);
    chk_flags(0, 0, "R10 watchdog over pin");
    slp = 1'b0;
    apply(4'b1001, 3); wait_rel(n);
    chk_flags(1, 1, "R10 power over watchdog");

    sel = 2'd1; apply(4'b0100, 3);
    repeat (40) @(negedge clk);
    check(sys_rst == 1'b1, "R2 still in start-up stage", int'(sys_rst), 1);
    apply(4'b1000, 3); wait_rel(n);
    chk_span(n, T1, "R2 restart runs full sequence");

    sel = 2'd0; ok = 1'b0; apply(4'b0100, 3);
    repeat (300) @(negedge clk);
    check(sys_rst == 1'b1, "R5 start-up waits for valid oscillator", int'(sys_rst), 1);
    ok = 1'b1; wait_rel(n);
    check(n >= 15 * OP && sys_rst == 1'b0, "R5 sixteen edges after valid", n, 16 * OP);

    apply(4'b0100, 200); wait_rel(n);
    chk_span(n, T0, "R3 delay starts after long request");

    done_f = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done_f) begin
      done_f = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule